// File: doc/BRIEF.md
# Filterless Three-Level PWM Modulator

This block turns one signed audio sample per switching period into the two logic-level gate commands for one H-bridge channel. Both commands come from a single up/down triangle carrier. The positive leg is compared against the sample and the negative leg against its negation, so each leg's pulse sits at the centre of the period. With a zero sample the two legs switch together at 50% duty, and the load sees almost no differential voltage. A positive sample widens the positive leg and narrows the negative leg by the same amount. A negative sample does the opposite.

The switching period is `PERIOD_CLKS` system clocks. The default of 416 clocks at 125 MHz gives about 300 kHz. One sample LSB is one clock of half-duty offset, so each leg's high time changes by two clocks per LSB. A sample written with `sample_vld` is held and goes into use only at the next period boundary. The mono control is also captured at that boundary. In mono mode both legs carry the positive-leg waveform, so the two outputs can be tied together. A signed per-period differential duty is provided for a fault monitor. When `enable` is low, the block forces both legs low and raises a high-impedance request for the output stage.

Top module: `tri_level_pwm`

## Requirements
- R1: With an active sample of zero and mono off, both legs are high for exactly PERIOD_CLKS/2 clocks per period, and they are equal in every clock.
- R2: With an active sample s > 0 (s in clocks), the positive leg is high for PERIOD_CLKS/2 + 2s clocks and the negative leg is high for PERIOD_CLKS/2 - 2s clocks in each period.
- R3: With an active sample s < 0, the same formulas apply, so the positive leg is below 50% duty and the negative leg is above 50% duty.
- R4: `period_start` is high for exactly one clock every PERIOD_CLKS clocks. This clock is phase index 0 of a period. The first period starts in the first clock after reset release.
- R5: A sample accepted with `sample_vld` during a period, and the level of `mono` during a period, have no effect on the outputs or on `diff_duty` until the next period starts. The most recently accepted sample is then used.
- R6: The sample is saturated to ±(PERIOD_CLKS/4 - 1). While enabled, both legs are low at phase index 0 and high at phase indices PERIOD_CLKS/2 - 1 and PERIOD_CLKS/2. Neither leg is therefore ever stuck at 0% or 100%.
- R7: The high pulses are centred in the period. The positive leg is high from index PERIOD_CLKS/4 - s to PERIOD_CLKS - 1 - (PERIOD_CLKS/4 - s). The negative leg is high from index PERIOD_CLKS/4 + s to the mirror of that index.
- R8: When `mono` is 1 at a period start, both legs carry the positive-leg waveform for that whole period. They are identical in every clock.
- R9: While `enable` is low, both legs are low and `out_hiz` is 1, starting from the first clock edge that samples it low. While `enable` is high, `out_hiz` is 0.
- R10: `diff_duty` changes only at a period start. It then holds 4·s for that period, which is the positive-leg high count minus the negative-leg high count, using the saturated s. It holds 0 if mono was on or enable was low at that period start.
- R11: While reset is asserted, `out_pos`, `out_neg`, `period_start` and `diff_duty` are 0 and `out_hiz` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Output drive enable; low forces both legs low |
| mono | input | 1 | Parallel mode: both legs follow the positive leg (taken at period start) |
| sample_in | input | SAMPLE_W (16) | Signed sample, in clocks of half-duty offset |
| sample_vld | input | 1 | Accept `sample_in` this clock |
| out_pos | output | 1 | Positive-leg gate command |
| out_neg | output | 1 | Negative-leg gate command |
| out_hiz | output | 1 | High-impedance request for the output stage |
| period_start | output | 1 | One-clock pulse at phase index 0 of each period |
| diff_duty | output | DW (10) | Signed positive-minus-negative high count of the current period |

## Verification
The bench goes after the saturation boundary: a sample one above the limit must give the same waveform as the limit itself. A design that clamps off by one would either stick a leg at 100%, with no low clock at the period edge, or lose the last usable step. It writes a new sample and flips mono at mid-period, and checks that the running period keeps its old shape. A design that loads immediately would show a duty that matches neither sample, or would merge the legs part-way through the period. It also measures where each pulse starts and ends and checks the idle and mono cases clock by clock. A comparator wired to the wrong sample sign, or an edge-aligned carrier, would shift the pulse or break the in-phase relation. Disable and re-enable are checked over whole periods for zero drive and for the reported differential duty.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  // One bit per bridge leg, kept together through the output register.
  typedef struct packed {
    logic pos;
    logic neg;
  } leg_pair_t;

  localparam int NUM_LEGS = 2;

endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;

endmodule

// File: rtl/pwm_carrier.sv
module pwm_carrier #(
  parameter int PERIOD_CLKS = 416,
  parameter int CW          = $clog2(PERIOD_CLKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] phase_q,
  output logic [CW-1:0] phase_nx,
  output logic          wrap
);

  localparam logic [CW-1:0] LAST = CW'(PERIOD_CLKS - 1);

  // Next-state: free-running phase index, wrapping at the period end.
  always_comb begin
    wrap     = (phase_q == LAST);
    phase_nx = wrap ? '0 : phase_q + 1'b1;
  end

  // Reset to the last index so that the first clock after release opens a period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= LAST;
    end else begin
      phase_q <= phase_nx;
    end
  end

endmodule

// File: rtl/pwm_sample_stage.sv
module pwm_sample_stage #(
  parameter int SAMPLE_W    = 16,
  parameter int PERIOD_CLKS = 416,
  parameter int CW          = $clog2(PERIOD_CLKS),
  parameter int DW          = CW + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic signed [SAMPLE_W-1:0] sample_in,
  input  logic                       sample_vld,
  input  logic                       wrap,
  input  logic                       mono,
  input  logic                       enable,
  output logic signed [CW-1:0]       act_nx,
  output logic                       mono_nx,
  output logic signed [CW-1:0]       act_q,
  output logic                       mono_q,
  output logic signed [DW-1:0]       diff_q
);

  localparam int                         LIM   = PERIOD_CLKS / 4 - 1;
  localparam logic signed [SAMPLE_W-1:0] LIM_S = SAMPLE_W'(LIM);

  logic signed [SAMPLE_W-1:0] pend_q;
  logic signed [SAMPLE_W-1:0] pend_nx;
  logic signed [CW-1:0]       clamped;
  logic signed [DW-1:0]       diff_nx;

  // Holding register: the newest accepted sample waits for the boundary.
  always_comb begin
    pend_nx = sample_vld ? sample_in : pend_q;
  end

  // Saturation keeps one low and one high clock on each leg.
  always_comb begin
    if (pend_q > LIM_S) begin
      clamped = CW'(LIM_S);
    end else if (pend_q < -LIM_S) begin
      clamped = CW'(-LIM_S);
    end else begin
      clamped = CW'(pend_q);
    end
  end

  // Period-boundary load of the active sample, mode and reported duty.
  always_comb begin
    act_nx  = wrap ? clamped : act_q;
    mono_nx = wrap ? mono    : mono_q;
    diff_nx = diff_q;
    if (wrap) begin
      diff_nx = (enable && !mono) ? DW'(clamped * 4) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
      mono_q <= 1'b0;
      diff_q <= '0;
    end else begin
      pend_q <= pend_nx;
      act_q  <= act_nx;
      mono_q <= mono_nx;
      diff_q <= diff_nx;
    end
  end

endmodule

// File: rtl/pwm_compare.sv
module pwm_compare
  import pwm_pkg::*;
#(
  parameter int PERIOD_CLKS = 416,
  parameter int CW          = $clog2(PERIOD_CLKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CW-1:0]        phase_nx,
  input  logic signed [CW-1:0] act_nx,
  input  logic                 mono_nx,
  input  logic                 enable,
  output leg_pair_t            legs_q,
  output logic                 hiz_q,
  output logic                 start_q
);

  localparam int            HALF = PERIOD_CLKS / 2;
  localparam int            QTR  = PERIOD_CLKS / 4;
  localparam int            TH   = CW + 2;
  localparam logic [CW-1:0] LAST = CW'(PERIOD_CLKS - 1);

  logic [CW-1:0]        tri_nx;
  logic signed [TH-1:0] tri_x;
  logic signed [TH-1:0] thr [NUM_LEGS];
  logic [NUM_LEGS-1:0]  hi_nx;

  // Triangle value for the coming clock: up for the first half, mirrored down.
  always_comb begin
    tri_nx = (phase_nx < CW'(HALF)) ? phase_nx : (LAST - phase_nx);
    tri_x  = $signed({2'b00, tri_nx});
  end

  // Leg 0 compares against +sample, leg 1 against -sample (or +sample in mono).
  always_comb begin
    thr[0] = TH'(QTR) - TH'(act_nx);
    thr[1] = mono_nx ? thr[0] : (TH'(QTR) + TH'(act_nx));
  end

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    assign hi_nx[g] = enable && (tri_x >= thr[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      legs_q  <= '0;
      hiz_q   <= 1'b1;
      start_q <= 1'b0;
    end else begin
      legs_q.pos <= hi_nx[0];
      legs_q.neg <= hi_nx[1];
      hiz_q      <= !enable;
      start_q    <= (phase_nx == '0);
    end
  end

endmodule

// File: rtl/tri_level_pwm.sv
module tri_level_pwm
  import pwm_pkg::*;
#(
  parameter int  PERIOD_CLKS = 416,
  parameter int  SAMPLE_W    = 16,
  localparam int CW          = $clog2(PERIOD_CLKS),
  localparam int DW          = CW + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       enable,
  input  logic                       mono,
  input  logic signed [SAMPLE_W-1:0] sample_in,
  input  logic                       sample_vld,
  output logic                       out_pos,
  output logic                       out_neg,
  output logic                       out_hiz,
  output logic                       period_start,
  output logic signed [DW-1:0]       diff_duty
);

  logic                 rst_n_int;
  logic [CW-1:0]        phase_q;
  logic [CW-1:0]        phase_nx;
  logic                 wrap;
  logic signed [CW-1:0] act_nx;
  logic signed [CW-1:0] act_q;
  logic                 mono_nx;
  logic                 mono_q;
  leg_pair_t            legs_q;

  pwm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  pwm_carrier #(
    .PERIOD_CLKS (PERIOD_CLKS),
    .CW          (CW)
  ) u_carrier (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .phase_q  (phase_q),
    .phase_nx (phase_nx),
    .wrap     (wrap)
  );

  pwm_sample_stage #(
    .SAMPLE_W    (SAMPLE_W),
    .PERIOD_CLKS (PERIOD_CLKS),
    .CW          (CW),
    .DW          (DW)
  ) u_sample (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .sample_in  (sample_in),
    .sample_vld (sample_vld),
    .wrap       (wrap),
    .mono       (mono),
    .enable     (enable),
    .act_nx     (act_nx),
    .mono_nx    (mono_nx),
    .act_q      (act_q),
    .mono_q     (mono_q),
    .diff_q     (diff_duty)
  );

  pwm_compare #(
    .PERIOD_CLKS (PERIOD_CLKS),
    .CW          (CW)
  ) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .phase_nx (phase_nx),
    .act_nx   (act_nx),
    .mono_nx  (mono_nx),
    .enable   (enable),
    .legs_q   (legs_q),
    .hiz_q    (out_hiz),
    .start_q  (period_start)
  );

  assign out_pos = legs_q.pos;
  assign out_neg = legs_q.neg;

endmodule

// File: rtl/tri_level_pwm_chk.sv
module tri_level_pwm_chk #(
  parameter int PERIOD_CLKS = 416,
  parameter int CW          = $clog2(PERIOD_CLKS),
  parameter int DW          = CW + 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 out_pos,
  input logic                 out_neg,
  input logic                 out_hiz,
  input logic                 period_start,
  input logic signed [DW-1:0] diff_duty,
  input logic [CW-1:0]        phase_q,
  input logic signed [CW-1:0] act_q,
  input logic                 mono_q
);

  localparam int                   HALF  = PERIOD_CLKS / 2;
  localparam logic signed [DW-1:0] DMAX  = DW'(4 * (PERIOD_CLKS / 4 - 1));

  AST_IDLE_INPHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q == '0) |-> (out_pos == out_neg)); // R1

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |=> !period_start); // R4

  AST_DIFF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start |-> $stable(diff_duty)); // R5

  AST_PEAK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_hiz && (phase_q == CW'(HALF - 1) || phase_q == CW'(HALF))) |-> (out_pos && out_neg)); // R6

  AST_EDGE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_hiz && phase_q == '0) |-> (!out_pos && !out_neg)); // R6

  AST_MONO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    mono_q |-> (out_pos == out_neg)); // R8

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_hiz |-> (!out_pos && !out_neg)); // R9

  AST_DIFF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (diff_duty <= DMAX) && (diff_duty >= -DMAX) && (diff_duty[1:0] == 2'b00)); // R10

endmodule

bind tri_level_pwm tri_level_pwm_chk #(
  .PERIOD_CLKS (PERIOD_CLKS),
  .CW          (CW),
  .DW          (DW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .out_pos      (out_pos),
  .out_neg      (out_neg),
  .out_hiz      (out_hiz),
  .period_start (period_start),
  .diff_duty    (diff_duty),
  .phase_q      (phase_q),
  .act_q        (act_q),
  .mono_q       (mono_q)
);

// File: tb/tri_level_pwm_bench.sv
`timescale 1ns/1ps
module tri_level_pwm_bench;

  localparam int PERIOD = 416;
  localparam int HALF   = PERIOD / 2;
  localparam int QTR    = PERIOD / 4;
  localparam int LIM    = QTR - 1;

  logic               clk;
  logic               rst_n;
  logic               enable;
  logic               mono;
  logic signed [15:0] sample_in;
  logic               sample_vld;
  logic               out_pos;
  logic               out_neg;
  logic               out_hiz;
  logic               period_start;
  logic signed [9:0]  diff_duty;

  int n_checks;
  int n_fail;
  int cnt_p, cnt_n, cnt_mis, cnt_hiz, first_p, last_p, first_n, last_n;
  int bad_start, bad_edge, diff_chg, diff0;

  tri_level_pwm u_tri_level_pwm (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .mono         (mono),
    .sample_in    (sample_in),
    .sample_vld   (sample_vld),
    .out_pos      (out_pos),
    .out_neg      (out_neg),
    .out_hiz      (out_hiz),
    .period_start (period_start),
    .diff_duty    (diff_duty)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  task automatic chk(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int clampv(int s);
    if (s > LIM) return LIM;
    if (s < -LIM) return -LIM;
    return s;
  endfunction

  task automatic set_sample(int s);
    sample_in  = 16'(s);
    sample_vld = 1'b1;
    @(negedge clk);
    sample_vld = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_start();
    do @(negedge clk); while (!period_start);
  endtask

  // Observes one whole period; caller is at phase index 0 of that period.
  task automatic measure(bit inj, int inj_s, bit inj_m);
    cnt_p = 0; cnt_n = 0; cnt_mis = 0; cnt_hiz = 0;
    first_p = -1; last_p = -1; first_n = -1; last_n = -1;
    bad_start = 0; bad_edge = 0; diff_chg = 0;
    diff0 = int'(diff_duty);
    for (int i = 0; i < PERIOD; i++) begin
      if ((i == 0) != period_start) bad_start++;
      if (out_pos) begin cnt_p++; if (first_p < 0) first_p = i; last_p = i; end
      if (out_neg) begin cnt_n++; if (first_n < 0) first_n = i; last_n = i; end
      if (out_pos != out_neg) cnt_mis++;
      if (out_hiz) cnt_hiz++;
      if (int'(diff_duty) != diff0) diff_chg++;
      if (!out_hiz && i == 0 && (out_pos || out_neg)) bad_edge++;
      if (!out_hiz && (i == HALF - 1 || i == HALF) && !(out_pos && out_neg)) bad_edge++;
      if (inj && i == 100) begin sample_in = 16'(inj_s); sample_vld = 1'b1; mono = inj_m; end
      if (inj && i == 101) sample_vld = 1'b0;
      @(negedge clk);
    end
    if (!period_start) bad_start++;
  endtask

  task automatic expect_wave(string tag, int s, bit m);
    int sc = clampv(s);
    int ep = HALF + 2 * sc;
    int fp = QTR - sc;
    int fn = m ? fp : QTR + sc;
    chk({tag, " pos high count"}, cnt_p, ep);
    chk({tag, " neg high count"}, cnt_n, m ? ep : HALF - 2 * sc);
    chk({tag, " R7 pos first high"}, first_p, fp);
    chk({tag, " R7 pos last high"}, last_p, PERIOD - 1 - fp);
    chk({tag, " R7 neg first high"}, first_n, fn);
    chk({tag, " R7 neg last high"}, last_n, PERIOD - 1 - fn);
    chk({tag, " R10 diff_duty"}, diff0, m ? 0 : 4 * sc);
    chk({tag, " R10 diff held"}, diff_chg, 0);
    chk({tag, " R4 period_start"}, bad_start, 0);
    chk({tag, " R6 edge/peak pulses"}, bad_edge, 0);
    chk({tag, " R9 hiz low"}, cnt_hiz, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; enable = 1'b1; mono = 1'b0; sample_in = '0; sample_vld = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 out_pos in reset", int'(out_pos), 0);
    chk("R11 out_neg in reset", int'(out_neg), 0);
    chk("R11 out_hiz in reset", int'(out_hiz), 1);
    chk("R11 period_start in reset", int'(period_start), 0);
    chk("R11 diff_duty in reset", int'(diff_duty), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_idle();
    wait_start();
    measure(1'b0, 0, 1'b0);
    expect_wave("R1 idle", 0, 1'b0);
    chk("R1 idle legs differ", cnt_mis, 0);
  endtask

  task automatic t_level(string tag, int s);
    set_sample(s);
    wait_start();
    measure(1'b0, 0, 1'b0);
    expect_wave(tag, s, 1'b0);
  endtask

  task automatic t_midchange();
    measure(1'b1, 0, 1'b0);
    expect_wave("R5 old sample kept", 103, 1'b0);
    measure(1'b0, 0, 1'b0);
    expect_wave("R5 new sample used", 0, 1'b0);
  endtask

  task automatic t_mono();
    set_sample(-37);
    wait_start();
    measure(1'b1, 20, 1'b1);
    expect_wave("R5 mono late ignored", -37, 1'b0);
    chk("R5 legs still differ", int'(cnt_mis > 0), 1);
    measure(1'b0, 0, 1'b0);
    expect_wave("R8 mono", 20, 1'b1);
    chk("R8 mono legs differ", cnt_mis, 0);
  endtask

  task automatic t_enable();
    mono = 1'b0;
    enable = 1'b0;
    wait_start();
    measure(1'b0, 0, 1'b0);
    chk("R9 off pos high", cnt_p, 0);
    chk("R9 off neg high", cnt_n, 0);
    chk("R9 off hiz count", cnt_hiz, PERIOD);
    chk("R10 off diff_duty", diff0, 0);
    enable = 1'b1;
    wait_start();
    measure(1'b0, 0, 1'b0);
    expect_wave("R9 re-enabled", 20, 1'b0);
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    t_reset();
    t_idle();
    t_level("R2 positive", 20);
    t_level("R3 negative", -37);
    t_level("R6 saturate high", 30000);
    t_level("R6 saturate low", -30000);
    t_level("R6 one above limit", 104);
    t_level("R6 at limit", 103);
    t_midchange();
    t_mono();
    t_enable();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule